// File: doc/BRIEF.md
# Bytecode Stack Machine Core

This block is a small processor core that executes a byte-coded program on an operand stack of 32-bit words. Every instruction is one opcode byte, fetched from an instruction port that returns data in the same cycle as the address. The three newest stack words sit in registers (top, second, third). Anything deeper lives in an external single-port stack RAM with synchronous read. A push onto three full registers moves the third register out to RAM. A double pop sends one or two reads to RAM to fill the registers again, and the core shows `busy` while those reads are in progress.

The architectural state is a program counter, a stack pointer that counts the valid stack words, and a free space pointer. No instruction in this set moves the free space pointer; it holds its reset base for use by later heap logic. The core runs only after a reset held for four clock cycles. It stops for good on an unknown opcode, on a stack underflow and on a stack overflow. After that only a new reset restarts it.

Top module: `bytecode_stack_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it drops, `pc` and `sp` are 0, `busy` and `fault` are 0, and `freePtr` equals FREE_INIT.
- R2: The core starts executing only if `rst` was sampled high on at least four consecutive clock edges. It executes the first opcode at the second rising edge after `rst` is sampled low. A shorter reset pulse leaves the core idle, with `pc` and `sp` held at 0.
- R3: `imemAddr` always equals `pc`. In a cycle where the core is running and not busy, exactly one opcode is executed.
- R4: An opcode 0x40..0x4F pushes its low nibble, zero-extended to 32 bits. `sp` rises by 1 and `pc` by 1.
- R5: Opcode 0x12 needs at least one word on the stack. `pc` loads the low PC_W bits of the top word, and the top word becomes the old `pc`+1, zero-extended. `sp` does not change.
- R6: Opcode 0x0C needs at least two words. It exchanges the top and second words, `sp` does not change, and `pc` rises by 1.
- R7: Opcode 0x16 needs at least two words. It pops the top word (jump target) and then the second word (condition), so `sp` falls by 2. If the condition is nonzero, `pc` loads the low PC_W bits of the target; otherwise `pc` rises by 1.
- R8: After opcode 0x16 with old `sp` of 2 or 3, no RAM read is made. With old `sp` of 4, one read is made and `busy` is high for 1 cycle. With old `sp` of 5 or more, two reads are made and `busy` is high for 2 cycles. Once `busy` is low, the top min(`sp`,3) registers hold the newest stack words.
- R9: A push with `sp` of 3 or more writes the third register to RAM address `sp`-3 in the execute cycle. No other cycle writes the RAM.
- R10: Any opcode other than 0x4X, 0x12, 0x0C and 0x16 sets `fault`. The fault stays set, and `pc`, `sp` and the stack stay frozen until reset.
- R11: A stack underflow (0x12 with `sp`=0, or 0x0C or 0x16 with `sp`<2) sets `fault`, and so does a push with `sp` at STACK_MAX (RAM_DEPTH+3). The state freezes as in R10.
- R12: `freePtr` holds FREE_INIT at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, must be held 4 cycles |
| imemAddr | output | PC_W | Instruction memory address |
| imemData | input | 8 | Opcode byte at `imemAddr`, same cycle |
| ramAddr | output | RAM_AW | Stack RAM address |
| ramWe | output | 1 | Stack RAM write enable |
| ramWdata | output | DATA_W | Stack RAM write data |
| ramRdata | input | DATA_W | Stack RAM read data, one cycle after address |
| pc | output | PC_W | Program counter |
| sp | output | SP_W | Number of valid stack words |
| tosTop | output | DATA_W | Top stack register |
| tosSecond | output | DATA_W | Second stack register |
| tosThird | output | DATA_W | Third stack register |
| freePtr | output | DATA_W | Free space pointer |
| busy | output | 1 | Refill reads in progress, no fetch |
| fault | output | 1 | Sticky halt on bad opcode or stack bound |

## Verification
The assertions assume a stack RAM that returns the word last written to an address on the cycle after that address is presented. They also assume that `rst` changes only away from the rising edge. The bench meets both assumptions: its RAM model is a synchronous array, and `rst` is driven on falling edges. Programs are written so that jump and call targets land on valid code. Stack depth walks across the points where spill and refill start, and climbs until the overflow bound is reached, so the bound is the only place where the stack leaves its legal range.

// File: rtl/bytecode_stack_pkg.sv
package bytecode_stack_pkg;

  localparam logic [3:0] OP_PUSH_HI = 4'h4;
  localparam logic [7:0] OP_CALL    = 8'h12;
  localparam logic [7:0] OP_SWAP    = 8'h0C;
  localparam logic [7:0] OP_JNZ     = 8'h16;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_EXEC,
    ST_FILL1,
    ST_FILL2,
    ST_HALT
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       doPush;
    logic       doSpill;
    logic       doCall;
    logic       doSwap;
    logic       doJnz;
    logic       rdFirst;
    logic       rdSecond;
    logic       fillOne;
    logic       fillTwo;
    logic [3:0] pushNib;
  } dpCmd_t;

endpackage

// File: rtl/bytecode_stack_ctrl.sv
module bytecode_stack_ctrl
  import bytecode_stack_pkg::*;
#(
  parameter int SP_W      = 5,
  parameter int STACK_MAX = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      opcode,
  input  logic [SP_W-1:0] sp,
  output dpCmd_t          cmd,
  output logic            busy,
  output logic            fault
);

  logic [3:0] rstHist;
  ctrlState_t state, stateNext;
  logic twoReads, twoReadsNext;
  logic raiseFault;

  // history of the reset input; the core arms only after four high samples
  always_ff @(posedge clk) begin
    rstHist <= {rstHist[2:0], rst};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HOLD;
      twoReads <= 1'b0;
      fault    <= 1'b0;
    end else begin
      state    <= stateNext;
      twoReads <= twoReadsNext;
      if (raiseFault) fault <= 1'b1;
    end
  end

  always_comb begin
    cmd          = '0;
    stateNext    = state;
    twoReadsNext = twoReads;
    raiseFault   = 1'b0;
    case (state)
      ST_HOLD: begin
        if (rstHist == 4'hF) stateNext = ST_EXEC;
      end
      ST_EXEC: begin
        if (opcode[7:4] == OP_PUSH_HI) begin
          if (sp == SP_W'(STACK_MAX)) begin
            raiseFault = 1'b1;
          end else begin
            cmd.doPush  = 1'b1;
            cmd.pushNib = opcode[3:0];
            cmd.doSpill = (sp >= SP_W'(3));
          end
        end else if (opcode == OP_CALL) begin
          if (sp == '0) raiseFault = 1'b1;
          else          cmd.doCall = 1'b1;
        end else if (opcode == OP_SWAP) begin
          if (sp < SP_W'(2)) raiseFault = 1'b1;
          else               cmd.doSwap = 1'b1;
        end else if (opcode == OP_JNZ) begin
          if (sp < SP_W'(2)) begin
            raiseFault = 1'b1;
          end else begin
            cmd.doJnz = 1'b1;
            if (sp >= SP_W'(5)) begin
              cmd.rdFirst  = 1'b1;
              twoReadsNext = 1'b1;
              stateNext    = ST_FILL1;
            end else if (sp == SP_W'(4)) begin
              cmd.rdFirst  = 1'b1;
              twoReadsNext = 1'b0;
              stateNext    = ST_FILL1;
            end
          end
        end else begin
          raiseFault = 1'b1;
        end
        if (raiseFault) stateNext = ST_HALT;
      end
      ST_FILL1: begin
        cmd.fillOne = 1'b1;
        if (twoReads) begin
          cmd.rdSecond = 1'b1;
          stateNext    = ST_FILL2;
        end else begin
          stateNext = ST_EXEC;
        end
      end
      ST_FILL2: begin
        cmd.fillTwo = 1'b1;
        stateNext   = ST_EXEC;
      end
      default: stateNext = state;
    endcase
  end

  assign busy = (state == ST_FILL1) || (state == ST_FILL2);

endmodule

// File: rtl/bytecode_stack_dpath.sv
module bytecode_stack_dpath
  import bytecode_stack_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                PC_W      = 8,
  parameter int                SP_W      = 5,
  parameter int                RAM_AW    = 4,
  parameter logic [DATA_W-1:0] FREE_INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic [DATA_W-1:0] tosTop,
  output logic [DATA_W-1:0] tosSecond,
  output logic [DATA_W-1:0] tosThird,
  output logic [DATA_W-1:0] freePtr
);

  logic [PC_W-1:0]   pcPlus1;
  logic [RAM_AW-1:0] spLow;

  assign pcPlus1 = pc + PC_W'(1);
  assign spLow   = sp[RAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      sp        <= '0;
      tosTop    <= '0;
      tosSecond <= '0;
      tosThird  <= '0;
      freePtr   <= FREE_INIT;
    end else begin
      if (cmd.doPush) begin
        tosTop    <= DATA_W'(cmd.pushNib);
        tosSecond <= tosTop;
        tosThird  <= tosSecond;
        sp        <= sp + SP_W'(1);
        pc        <= pcPlus1;
      end
      if (cmd.doCall) begin
        pc     <= tosTop[PC_W-1:0];
        tosTop <= DATA_W'(pcPlus1);
      end
      if (cmd.doSwap) begin
        tosTop    <= tosSecond;
        tosSecond <= tosTop;
        pc        <= pcPlus1;
      end
      if (cmd.doJnz) begin
        pc     <= (tosSecond != '0) ? tosTop[PC_W-1:0] : pcPlus1;
        tosTop <= tosThird;
        sp     <= sp - SP_W'(2);
      end
      if (cmd.fillOne) tosSecond <= ramRdata;
      if (cmd.fillTwo) tosThird  <= ramRdata;
    end
  end

  // RAM word index equals stack position; rdFirst uses the pre-pop count,
  // rdSecond the already-updated count
  always_comb begin
    if (cmd.doSpill)       ramAddr = spLow - RAM_AW'(3);
    else if (cmd.rdFirst)  ramAddr = spLow - RAM_AW'(4);
    else if (cmd.rdSecond) ramAddr = spLow - RAM_AW'(3);
    else                   ramAddr = '0;
  end

  assign ramWe    = cmd.doSpill;
  assign ramWdata = tosThird;

endmodule

// File: rtl/bytecode_stack_core.sv
module bytecode_stack_core
  import bytecode_stack_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                PC_W      = 8,
  parameter int                RAM_DEPTH = 16,
  parameter logic [DATA_W-1:0] FREE_INIT = 32'h0000_0100,
  localparam int               RAM_AW    = $clog2(RAM_DEPTH),
  localparam int               STACK_MAX = RAM_DEPTH + 3,
  localparam int               SP_W      = $clog2(STACK_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   imemAddr,
  input  logic [7:0]        imemData,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [PC_W-1:0]   pc,
  output logic [SP_W-1:0]   sp,
  output logic [DATA_W-1:0] tosTop,
  output logic [DATA_W-1:0] tosSecond,
  output logic [DATA_W-1:0] tosThird,
  output logic [DATA_W-1:0] freePtr,
  output logic              busy,
  output logic              fault
);

  dpCmd_t cmd;

  bytecode_stack_ctrl #(
    .SP_W     (SP_W),
    .STACK_MAX(STACK_MAX)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .opcode(imemData),
    .sp    (sp),
    .cmd   (cmd),
    .busy  (busy),
    .fault (fault)
  );

  bytecode_stack_dpath #(
    .DATA_W   (DATA_W),
    .PC_W     (PC_W),
    .SP_W     (SP_W),
    .RAM_AW   (RAM_AW),
    .FREE_INIT(FREE_INIT)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .ramRdata (ramRdata),
    .ramAddr  (ramAddr),
    .ramWe    (ramWe),
    .ramWdata (ramWdata),
    .pc       (pc),
    .sp       (sp),
    .tosTop   (tosTop),
    .tosSecond(tosSecond),
    .tosThird (tosThird),
    .freePtr  (freePtr)
  );

  assign imemAddr = pc;

endmodule

// File: rtl/bytecode_stack_chk.sv
module bytecode_stack_chk #(
  parameter int DATA_W    = 32,
  parameter int PC_W      = 8,
  parameter int SP_W      = 5,
  parameter int STACK_MAX = 19
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   pc,
  input logic [SP_W-1:0]   sp,
  input logic              busy,
  input logic              fault,
  input logic              ramWe,
  input logic [DATA_W-1:0] freePtr
);

  // R8: no fetch while refilling, so pc holds across busy cycles
  assert_fill_pc_stable_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(pc));

  // R8: refill never lasts more than two cycles
  assert_fill_len_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

  // R10: fault is sticky
  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  // R10: halted core changes neither pc nor sp
  assert_halt_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    fault |=> ($stable(pc) && $stable(sp)));

  // R9: a spill write happens only when the registers are full
  assert_spill_when_full_R9: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> (sp >= SP_W'(3)));

  // R9: every spill belongs to a push
  assert_spill_push_R9: assert property (@(posedge clk) disable iff (rst)
    ramWe |=> (sp == $past(sp) + SP_W'(1)));

  // R11: depth never passes the bound
  assert_sp_bound_R11: assert property (@(posedge clk) disable iff (rst)
    sp <= SP_W'(STACK_MAX));

  // R12: free space pointer is untouched
  assert_free_ptr_R12: assert property (@(posedge clk) disable iff (rst)
    $stable(freePtr));

endmodule

bind bytecode_stack_core bytecode_stack_chk #(
  .DATA_W   (DATA_W),
  .PC_W     (PC_W),
  .SP_W     (SP_W),
  .STACK_MAX(STACK_MAX)
) u_chk (.*);

// File: tb/bytecode_stack_core_tb.sv
module bytecode_stack_core_tb;

  localparam int DATA_W    = 32;
  localparam int PC_W      = 8;
  localparam int RAM_DEPTH = 16;
  localparam int RAM_AW    = 4;
  localparam int STACK_MAX = RAM_DEPTH + 3;
  localparam int SP_W      = 5;
  localparam logic [31:0] FREE_INIT = 32'h0000_0100;

  localparam int M_HOLD = 0, M_EXEC = 1, M_BUSY = 2, M_HALT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [PC_W-1:0]   imemAddr;
  logic [7:0]        imemData;
  logic [RAM_AW-1:0] ramAddr;
  logic              ramWe;
  logic [DATA_W-1:0] ramWdata;
  logic [DATA_W-1:0] ramRdata;
  logic [PC_W-1:0]   pc;
  logic [SP_W-1:0]   sp;
  logic [DATA_W-1:0] tosTop, tosSecond, tosThird, freePtr;
  logic              busy, fault;

  logic [7:0]  rom [256];
  logic [31:0] ramMem [RAM_DEPTH];

  assign imemData = rom[imemAddr];

  always @(posedge clk) begin
    if (ramWe) ramMem[ramAddr] <= ramWdata;
    ramRdata <= ramMem[ramAddr];
  end

  bytecode_stack_core #(
    .DATA_W(DATA_W), .PC_W(PC_W), .RAM_DEPTH(RAM_DEPTH), .FREE_INIT(FREE_INIT)
  ) u_dut (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .pc(pc), .sp(sp), .tosTop(tosTop), .tosSecond(tosSecond), .tosThird(tosThird),
    .freePtr(freePtr), .busy(busy), .fault(fault)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit started = 0;
  bit done    = 0;

  // behavioural reference
  logic [31:0] stk [$];
  int          mState = M_HOLD;
  int          mPc = 0;
  int          busyLeft = 0;
  bit          mFault = 0;
  logic [3:0]  mHist = 4'h0;
  string       lastTag = "R1";

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic raiseFault(input string tag);
    mFault  = 1;
    mState  = M_HALT;
    lastTag = tag;
  endtask

  always @(posedge clk) begin
    bit armed;
    armed = (mHist == 4'hF);
    mHist = {mHist[2:0], rst};
    if (rst) begin
      mState = M_HOLD; stk.delete(); mPc = 0; mFault = 0; busyLeft = 0;
      lastTag = "R1";
    end else begin
      case (mState)
        M_HOLD: begin
          lastTag = "R2";
          if (armed) mState = M_EXEC;
        end
        M_BUSY: begin
          lastTag = "R8";
          busyLeft--;
          if (busyLeft == 0) mState = M_EXEC;
        end
        M_EXEC: begin
          logic [7:0] op;
          int n;
          op = rom[mPc];
          n  = stk.size();
          if (op[7:4] == 4'h4) begin
            if (n == STACK_MAX) raiseFault("R11");
            else begin
              stk.push_back({28'h0, op[3:0]});
              mPc = (mPc + 1) % 256; lastTag = "R4";
            end
          end else if (op == 8'h12) begin
            if (n < 1) raiseFault("R11");
            else begin
              logic [31:0] t;
              t = stk[n-1];
              stk[n-1] = 32'((mPc + 1) % 256);
              mPc = int'(t[7:0]); lastTag = "R5";
            end
          end else if (op == 8'h0C) begin
            if (n < 2) raiseFault("R11");
            else begin
              logic [31:0] t;
              t = stk[n-1]; stk[n-1] = stk[n-2]; stk[n-2] = t;
              mPc = (mPc + 1) % 256; lastTag = "R6";
            end
          end else if (op == 8'h16) begin
            if (n < 2) raiseFault("R11");
            else begin
              logic [31:0] tgt, cnd;
              tgt = stk.pop_back();
              cnd = stk.pop_back();
              mPc = (cnd != 0) ? int'(tgt[7:0]) : (mPc + 1) % 256;
              lastTag = "R7";
              busyLeft = (n >= 5) ? 2 : (n == 4) ? 1 : 0;
              if (busyLeft > 0) mState = M_BUSY;
            end
          end else begin
            raiseFault("R10");
          end
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      int n;
      bit expWe;
      n = stk.size();
      check(lastTag, "pc", pc, mPc);
      check(lastTag, "sp", sp, n);
      check("R8", "busy", busy, (mState == M_BUSY));
      check(lastTag, "fault", fault, mFault);
      check("R3", "imemAddr", imemAddr, pc);
      check("R12", "freePtr", freePtr, FREE_INIT);
      expWe = (mState == M_EXEC) && !rst && (rom[mPc][7:4] == 4'h4) &&
              (n >= 3) && (n < STACK_MAX);
      check("R9", "ramWe", ramWe, expWe);
      if (expWe) begin
        check("R9", "ramAddr", ramAddr, n - 3);
        check("R9", "ramWdata", ramWdata, stk[n-3]);
      end
      if (mState != M_BUSY) begin
        if (n >= 1) check(lastTag, "tosTop", tosTop, stk[n-1]);
        if (n >= 2) check(lastTag, "tosSecond", tosSecond, stk[n-2]);
        if (n >= 3) check(lastTag, "tosThird", tosThird, stk[n-3]);
      end
    end
  end

  task automatic loadProg(input int which);
    for (int a = 0; a < 256; a++) rom[a] = 8'hFF;
    case (which)
      0: begin // call, swap, spills, jumps taken and not taken, then overflow
        rom[0] = 8'h4A; rom[1] = 8'h44; rom[2] = 8'h12; rom[3] = 8'h00;
        rom[4] = 8'h0C; rom[5] = 8'h41; rom[6] = 8'h42; rom[7] = 8'h43;
        rom[8] = 8'h44; rom[9] = 8'h41; rom[10] = 8'h4E; rom[11] = 8'h16;
        rom[14] = 8'h40; rom[15] = 8'h4F; rom[16] = 8'h16; rom[17] = 8'h16;
      end
      1: begin // one-read and zero-read refills, then jnz underflow
        rom[0] = 8'h41; rom[1] = 8'h42; rom[2] = 8'h43; rom[3] = 8'h44;
        rom[4] = 8'h16;
      end
      2: begin // jnz from depth three, then underflow
        rom[0] = 8'h40; rom[1] = 8'h45; rom[2] = 8'h43; rom[3] = 8'h16;
      end
      3: begin // swap underflow
        rom[0] = 8'h41; rom[1] = 8'h0C;
      end
      4: begin // call underflow
        rom[0] = 8'h12;
      end
      default: begin // unknown opcode after a push
        rom[0] = 8'h47; rom[1] = 8'h2B;
      end
    endcase
  endtask

  task automatic fullReset(input int which);
    @(negedge clk);
    rst = 1'b1;
    loadProg(which);
    repeat (5) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    for (int a = 0; a < RAM_DEPTH; a++) ramMem[a] = '0;
    loadProg(0);
    @(posedge clk);
    started = 1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (300) @(negedge clk);
    check("R11", "overflow fault", fault, 1);
    fullReset(1);
    repeat (40) @(negedge clk);
    check("R11", "jnz underflow fault", fault, 1);
    // short reset pulse: core must stay idle (R2)
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check("R2", "idle pc after short reset", pc, 0);
    check("R2", "idle sp after short reset", sp, 0);
    fullReset(2);
    repeat (20) @(negedge clk);
    fullReset(3);
    repeat (20) @(negedge clk);
    check("R11", "swap underflow fault", fault, 1);
    fullReset(4);
    repeat (20) @(negedge clk);
    check("R11", "call underflow fault", fault, 1);
    fullReset(5);
    repeat (20) @(negedge clk);
    check("R10", "unknown opcode fault", fault, 1);
    check("R10", "frozen pc", pc, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule